// File: doc/BRIEF.md
# Two-Master External Bus Arbiter

This block decides which of two masters may drive a shared external bus: the local master inside the chip, or one master outside it. The outside master raises a request line. The arbiter answers on a grant line. Both masters report ownership on a shared busy line. After a grant the outside master has a short claim window in which it may assert busy. Once the grant is withdrawn, the local master is held off for a lockout period, so that a busy assertion arriving late is still seen. When the outside master does take the bus, the local master waits until busy has been low on enough consecutive samples before it takes the bus back. The local side uses a request/start handshake, a busy output of its own, a done input, and an output-enable for the shared control lines. The enable is low whenever the local master does not own the bus, so each handover leaves a gap in which neither master drives.

Everything is sampled on the rising clock edge. An optional synchronizer of `SYNC_STAGES` flops sits on the external request and busy inputs. Its default depth of zero keeps the cycle counts given below.

The controller is a six-state machine:
- `LOCAL_IDLE`: the local master owns an idle bus.
- `LOCAL_OWN`: a local access is in progress.
- `GRANTED_WINDOW`: the grant is out and the claim window is open.
- `LOCKOUT`: the grant has been withdrawn and the local master is still held off.
- `EXT_OWN`: the outside master owns the bus.
- `EXT_RELEASE`: busy has been seen low, and the block is waiting for it to stay low.

Its transitions are:
- `LOCAL_IDLE` to `GRANTED_WINDOW` when a request is seen. This has priority over a local request.
- `LOCAL_IDLE` to `LOCAL_OWN` when a start is issued.
- `LOCAL_OWN` to `LOCAL_IDLE` on done.
- `GRANTED_WINDOW` to `EXT_OWN` when busy is seen.
- `GRANTED_WINDOW` to `LOCKOUT` when the window expires.
- `LOCKOUT` to `EXT_OWN` when busy is seen.
- `LOCKOUT` to `LOCAL_IDLE` when the lockout expires.
- `EXT_OWN` to `EXT_RELEASE` when busy is seen low.
- `EXT_RELEASE` back to `EXT_OWN` when busy returns.
- `EXT_RELEASE` to `LOCAL_IDLE` when the last required idle sample arrives.

Top module: `xbus_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `grant_o` is 0, `ctrl_oe_o` is 1, `loc_start_o` is 0 and `loc_busy_o` is 0.
- R2: In `LOCAL_IDLE`, a 1 sampled on `ext_req_i` raises `grant_o` in the very next cycle. While `ext_req_i` is 1, `loc_start_o` stays 0 even if `loc_req_i` is 1.
- R3: If busy is not seen, `grant_o` stays high for exactly 2 cycles. If `ext_busy_i` is sampled high inside the window, the grant drops in the next cycle and the outside master owns the bus.
- R4: After `grant_o` falls, `loc_start_o` stays 0 for 3 cycles. If no busy was seen, it may rise in the 4th cycle, and in that cycle `ctrl_oe_o` returns to 1.
- R5: A busy assertion sampled during the window or the lockout defers any pending local request. `loc_start_o` and `ctrl_oe_o` stay 0 while the outside master owns the bus.
- R6: Ownership returns to the local master only after `ext_busy_i` has been sampled low on 2 consecutive edges. A single low sample followed by high keeps the local master waiting.
- R7: `loc_start_o` is 1 only in `LOCAL_IDLE`, with `loc_req_i` 1 and both external inputs 0. After a start, `loc_busy_o` is 1 from the next cycle until the edge at which `loc_done_i` is sampled 1.
- R8: `ctrl_oe_o` is 1 only while the local master owns the bus, and it is never 1 together with `grant_o`.
- R9: A request that arrives during a local access is not granted until `loc_done_i` has ended that access. The grant then follows one cycle after the arbiter is back in `LOCAL_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_req_i | input | 1 | Bus request from the outside master, active high |
| ext_busy_i | input | 1 | Shared busy line as seen on the bus, active high |
| loc_req_i | input | 1 | Local master wants the bus |
| loc_done_i | input | 1 | Local access finished; sampled while the local access is in progress |
| grant_o | output | 1 | Bus grant to the outside master, active high |
| loc_start_o | output | 1 | Local access may start this cycle |
| loc_busy_o | output | 1 | Local master drives busy on the shared line |
| ctrl_oe_o | output | 1 | Output enable for the local drivers of the shared control lines |

## Verification
The assertions assume the outside master follows the protocol in two ways. It asserts busy only while it holds a grant, or during the lockout that follows one. It keeps busy high for its whole access. The assertions also assume the local master raises done only while it owns the bus. The stimulus meets these assumptions by construction. Busy is driven high only at a chosen offset after a grant, sweeping every offset inside the window, every offset inside the lockout, and the case with no claim at all. Busy is dropped only during an external ownership, and done is pulsed only after a start.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;

    typedef enum logic [2:0] {
        LOCAL_IDLE     = 3'd0,
        LOCAL_OWN      = 3'd1,
        GRANTED_WINDOW = 3'd2,
        EXT_OWN        = 3'd3,
        EXT_RELEASE    = 3'd4,
        LOCKOUT        = 3'd5
    } arb_state_e;

endpackage

// File: rtl/xbus_sync.sv
`timescale 1ns/1ps
// Optional flop chain on the external inputs; zero stages is a pass-through.
module xbus_sync #(
    parameter int STAGES = 0,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [WIDTH-1:0] pipe [STAGES];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
                end else begin
                    pipe[0] <= d;
                    for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
                end
            end
            assign q = pipe[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/xbus_timer.sv
`timescale 1ns/1ps
// Counts cycles spent in the current state; cleared on every state change.
module xbus_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (cnt != {CW{1'b1}})
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/xbus_fsm.sv
`timescale 1ns/1ps
module xbus_fsm
    import xbus_pkg::*;
#(
    parameter int WIN_CYC  = 2,
    parameter int LOCK_CYC = 3,
    parameter int REL_IDLE = 2,
    parameter int CW       = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          br,
    input  logic          bb,
    input  logic          loc_req,
    input  logic          loc_done,
    input  logic [CW-1:0] cnt,
    output logic          state_chg,
    output logic          grant,
    output logic          start,
    output logic          loc_busy,
    output logic          ctrl_oe
);

    localparam logic [CW-1:0] WIN_LAST  = CW'(WIN_CYC - 1);
    localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_CYC - 1);
    localparam logic [CW-1:0] REL_LAST  = CW'(REL_IDLE - 2);

    arb_state_e state_q, state_d;
    logic       start_ok;

    assign start_ok  = loc_req && !br && !bb;
    assign state_chg = (state_d != state_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LOCAL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LOCAL_IDLE: begin
                if (br)            state_d = GRANTED_WINDOW;
                else if (start_ok) state_d = LOCAL_OWN;
            end
            LOCAL_OWN: begin
                if (loc_done)      state_d = LOCAL_IDLE;
            end
            GRANTED_WINDOW: begin
                if (bb)                   state_d = EXT_OWN;
                else if (cnt == WIN_LAST) state_d = LOCKOUT;
            end
            LOCKOUT: begin
                if (bb)                    state_d = EXT_OWN;
                else if (cnt == LOCK_LAST) state_d = LOCAL_IDLE;
            end
            EXT_OWN: begin
                if (!bb)           state_d = EXT_RELEASE;
            end
            EXT_RELEASE: begin
                if (bb)                   state_d = EXT_OWN;
                else if (cnt == REL_LAST) state_d = LOCAL_IDLE;
            end
            default:               state_d = LOCAL_IDLE;
        endcase
    end

    always_comb begin
        grant    = 1'b0;
        start    = 1'b0;
        loc_busy = 1'b0;
        ctrl_oe  = 1'b0;
        unique case (state_q)
            LOCAL_IDLE: begin
                ctrl_oe = 1'b1;
                start   = start_ok;
            end
            LOCAL_OWN: begin
                ctrl_oe  = 1'b1;
                loc_busy = 1'b1;
            end
            GRANTED_WINDOW: grant = 1'b1;
            LOCKOUT, EXT_OWN, EXT_RELEASE: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/xbus_arbiter.sv
`timescale 1ns/1ps
module xbus_arbiter #(
    parameter int SYNC_STAGES = 0,
    parameter int WIN_CYC     = 2,
    parameter int LOCK_CYC    = 3,
    parameter int REL_IDLE    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req_i,
    input  logic ext_busy_i,
    input  logic loc_req_i,
    input  logic loc_done_i,
    output logic grant_o,
    output logic loc_start_o,
    output logic loc_busy_o,
    output logic ctrl_oe_o
);

    localparam int MAX_CNT = (WIN_CYC > LOCK_CYC) ?
                             ((WIN_CYC > REL_IDLE) ? WIN_CYC : REL_IDLE) :
                             ((LOCK_CYC > REL_IDLE) ? LOCK_CYC : REL_IDLE);
    localparam int CW = $clog2(MAX_CNT + 1);

    logic [1:0]    raw_in, sync_in;
    logic          br_s, bb_s;
    logic          state_chg;
    logic [CW-1:0] cnt;

    assign raw_in = {ext_req_i, ext_busy_i};
    assign br_s   = sync_in[1];
    assign bb_s   = sync_in[0];

    xbus_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    xbus_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_chg),
        .cnt   (cnt)
    );

    xbus_fsm #(
        .WIN_CYC  (WIN_CYC),
        .LOCK_CYC (LOCK_CYC),
        .REL_IDLE (REL_IDLE),
        .CW       (CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .br        (br_s),
        .bb        (bb_s),
        .loc_req   (loc_req_i),
        .loc_done  (loc_done_i),
        .cnt       (cnt),
        .state_chg (state_chg),
        .grant     (grant_o),
        .start     (loc_start_o),
        .loc_busy  (loc_busy_o),
        .ctrl_oe   (ctrl_oe_o)
    );

endmodule

// File: rtl/xbus_arbiter_chk.sv
`timescale 1ns/1ps
module xbus_arbiter_chk #(
    parameter int WIN_CYC  = 2,
    parameter int LOCK_CYC = 3,
    parameter int REL_IDLE = 2
) (
    input logic clk,
    input logic rst_n,
    input logic br_s,
    input logic bb_s,
    input logic loc_done_i,
    input logic grant_o,
    input logic loc_start_o,
    input logic loc_busy_o,
    input logic ctrl_oe_o
);

    logic [7:0] since_grant;   // edges since grant was last high
    logic [7:0] idle_run;      // consecutive low busy samples
    logic [7:0] grant_run;     // consecutive grant cycles before this one

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_grant <= 8'hFF;
            idle_run    <= 8'hFF;
            grant_run   <= 8'd0;
        end else begin
            if (grant_o)                  since_grant <= 8'd0;
            else if (since_grant != 8'hFF) since_grant <= since_grant + 8'd1;
            if (bb_s)                     idle_run <= 8'd0;
            else if (idle_run != 8'hFF)   idle_run <= idle_run + 8'd1;
            if (!grant_o)                 grant_run <= 8'd0;
            else if (grant_run != 8'hFF)  grant_run <= grant_run + 8'd1;
        end
    end

    assert_grant_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_o) |-> $past(br_s));

    assert_window_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> (grant_run < 8'(WIN_CYC)));

    assert_lockout_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        loc_start_o |-> (since_grant >= 8'(LOCK_CYC)));

    assert_release_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        loc_start_o |-> (idle_run >= 8'(REL_IDLE)));

    assert_start_clear_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        loc_start_o |-> (!bb_s && !br_s));

    assert_start_then_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        loc_start_o |=> loc_busy_o);

    assert_busy_until_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_busy_o && !loc_done_i) |=> loc_busy_o);

    assert_no_drive_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && ctrl_oe_o));

    assert_busy_needs_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        loc_busy_o |-> ctrl_oe_o);

    assert_no_grant_in_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        loc_busy_o |-> !grant_o);

endmodule

bind xbus_arbiter xbus_arbiter_chk #(
    .WIN_CYC  (WIN_CYC),
    .LOCK_CYC (LOCK_CYC),
    .REL_IDLE (REL_IDLE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .br_s        (br_s),
    .bb_s        (bb_s),
    .loc_done_i  (loc_done_i),
    .grant_o     (grant_o),
    .loc_start_o (loc_start_o),
    .loc_busy_o  (loc_busy_o),
    .ctrl_oe_o   (ctrl_oe_o)
);

// File: tb/sim_xbus_arbiter.sv
`timescale 1ns/1ps
module sim_xbus_arbiter;

    localparam int WIN  = 2;
    localparam int LOCK = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic br = 1'b0, bb = 1'b0, lreq = 1'b0, ldone = 1'b0;
    logic grant, start, lbusy, oe;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    xbus_arbiter u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_req_i   (br),
        .ext_busy_i  (bb),
        .loc_req_i   (lreq),
        .loc_done_i  (ldone),
        .grant_o     (grant),
        .loc_start_o (start),
        .loc_busy_o  (lbusy),
        .ctrl_oe_o   (oe)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 grant in reset", grant, 1'b0);
        chk("R1 oe in reset", oe, 1'b1);
        chk("R1 start in reset", start, 1'b0);
        chk("R1 busy in reset", lbusy, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R1 grant after reset", grant, 1'b0);
        chk("R1 oe after reset", oe, 1'b1);

        // d = cycle after grant rise at which busy is driven; d = WIN+LOCK means never
        for (int d = 0; d <= WIN + LOCK; d++) begin
            lreq = 1'b1;
            br   = 1'b1;
            chk("R2 request beats local", start, 1'b0);
            tick();
            for (int t = 0; t <= WIN + LOCK; t++) begin
                logic in_run;
                in_run = (t <= d);
                if (t < WIN) begin
                    chk("R3 grant in window", grant, in_run);
                    chk("R8 oe off in window", oe, 1'b0);
                end else begin
                    chk("R3 grant gone after window", grant, 1'b0);
                end
                if (t < WIN + LOCK)
                    chk(in_run ? "R4 lockout holds start" : "R5 deferred start", start, 1'b0);
                else
                    chk(in_run ? "R4 start after lockout" : "R5 deferred start", start, in_run);
                if (!in_run)
                    chk("R5 oe off while ext owns", oe, 1'b0);
                else if (t == WIN + LOCK)
                    chk("R4 oe back after lockout", oe, 1'b1);
                if (t == 0) br = 1'b0;
                if (t == d && d < WIN + LOCK) bb = 1'b1;
                if (t < WIN + LOCK) tick();
            end

            if (d < WIN + LOCK) begin
                bb = 1'b0;
                tick();
                chk("R6 one idle sample not enough", start, 1'b0);
                bb = 1'b1;
                tick();
                chk("R6 busy again keeps waiting", start, 1'b0);
                bb = 1'b0;
                tick();
                chk("R6 first idle sample", start, 1'b0);
                chk("R6 oe still off", oe, 1'b0);
                tick();
                chk("R6 released after two idle", start, 1'b1);
                chk("R6 oe back", oe, 1'b1);
            end

            chk("R7 start with request", start, 1'b1);
            tick();
            lreq = 1'b0;
            chk("R7 busy after start", lbusy, 1'b1);
            chk("R7 start is a pulse", start, 1'b0);
            chk("R8 oe while local owns", oe, 1'b1);
            br = 1'b1;
            tick();
            chk("R9 no grant during access", grant, 1'b0);
            chk("R7 busy held until done", lbusy, 1'b1);
            ldone = 1'b1;
            lreq  = 1'b1;
            tick();
            ldone = 1'b0;
            chk("R7 busy ends on done", lbusy, 1'b0);
            chk("R9 still no grant", grant, 1'b0);
            chk("R2 request beats local", start, 1'b0);
            tick();
            chk("R9 grant after access", grant, 1'b1);
            br   = 1'b0;
            lreq = 1'b0;
            for (int k = 1; k <= WIN + LOCK; k++) begin
                tick();
                chk("R3 unclaimed grant length", grant, (k < WIN));
                chk("R4 oe during lockout", oe, (k == WIN + LOCK));
            end
            chk("R7 no start without request", start, 1'b0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule